// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a synchronous host and an external asynchronous static RAM of 32768 bytes. The host hands it one read or one write at a time over a valid/ready handshake. For each request the controller drives the byte address, an active-low select, an active-low output enable and an active-low write strobe. It holds each strobe phase for the number of clock cycles needed to meet the memory's nanosecond limits. All limits are parameters in nanoseconds. A clock-period parameter turns each limit into whole cycles, rounding up.

A read holds select and output enable low until the slowest access path has settled. The data bus is sampled on the last edge of that window, and a one-cycle read-valid flag is returned. A write holds output enable high and keeps the write strobe low long enough for the pulse-width, address-to-end and data-to-end limits. The write data is driven only around that pulse. A write that follows a read waits until the memory has had time to release the bus. The bus is split into an output value, an output-enable and an input, so the pad ring can build the tri-state buffer.

Top module: `asram_ctrl`

## Requirements
- R1: Out of reset, select, output enable and write strobe are all high, the data drive enable is low and `req_ready` is high.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` stays low while select is low, and each accepted request produces exactly one strobe cycle.
- R3: A read holds select and output enable low, with the write strobe high, for exactly RD cycles. RD is the rounded-up maximum of cycle time, address access, select access and output-enable access (14 cycles at 5 ns). The byte present on `mem_dq_in` at the last edge of that window appears on `rd_data`, with `rd_valid` high for one cycle.
- R4: A write holds select low, output enable high and the write strobe low for at least WL cycles. WL is the rounded-up maximum of write pulse, address-to-end-of-write, select-to-end-of-write and data setup (11 cycles at 5 ns).
- R5: Successive falling edges of select are at least the rounded-up read/write cycle time apart (14 cycles at 5 ns).
- R6: The data drive enable rises in the same cycle as the write strobe falls and drops one cycle after it rises. It is never high while output enable is low.
- R7: `mem_addr` stays constant while select is low.
- R8: The data drive enable never rises less than TA cycles after output enable last went high. TA is the rounded-up output release time (6 cycles at 5 ns). A write request waiting behind that window sees `req_ready` low, while a read request does not.
- R9: Every byte written to any address, including 0 and 32767, reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take the request this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address of the request |
| req_wdata | input | 8 | Byte to store on a write |
| rd_valid | output | 1 | One-cycle flag: `rd_data` holds read result |
| rd_data | output | 8 | Byte returned by the last read |
| mem_addr | output | 15 | Address to the memory |
| mem_cs_n | output | 1 | Active-low select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | 8 | Value for the data pins when driven |
| mem_dq_oe | output | 1 | Drive enable of the data pins |
| mem_dq_in | input | 8 | Value seen on the data pins |

## Verification
A wrong cycle count in the sequencer shows up as a strobe window of the wrong length. A read window that is one cycle short returns a corrupted byte on the next `rd_valid`, because the memory model gives valid data only in the final cycle of the access. A wrong turnaround count leaves the controller and the memory model driving the bus in the same cycle, and this is flagged in that cycle. A sequencer stuck in a busy state stops `rd_valid` and the write pulses, so the count of pulses against requests reveals it at the end of the run.

// File: rtl/asram_pkg.sv
package asram_pkg;

   // sequencer phases
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_READ  = 2'd1,
      PH_WLOW  = 2'd2,
      PH_WTAIL = 2'd3
   } asram_phase_e;

   // nanoseconds to whole clock cycles, rounded up
   function automatic int ns2cyc(input int ns, input int period_ns);
      return (ns + period_ns - 1) / period_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_cnt.sv
// Down counter: load a value, count to zero, hold there.
module asram_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         zero
);

   logic [W-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= val;
      else if (q != '0)
         q <= q - 1'b1;
   end

   assign zero = (q == '0);

endmodule

// File: rtl/asram_seq.sv
// Phase sequencer: handshake, phase order and counter loads.
module asram_seq
   import asram_pkg::*;
#(
   parameter int CNT_W    = 4,
   parameter int RD_CYC   = 7,
   parameter int WLOW_CYC = 6,
   parameter int TAIL_CYC = 2,
   parameter int TURN_CYC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             op_zero,
   input  logic             turn_zero,
   output asram_phase_e     ph_q,
   output asram_phase_e     ph_d,
   output logic             req_ready,
   output logic             accept,
   output logic             op_load,
   output logic [CNT_W-1:0] op_val,
   output logic             turn_load,
   output logic [CNT_W-1:0] turn_val,
   output logic             rd_done
);

   localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WLOW_LD = CNT_W'(WLOW_CYC - 1);
   localparam logic [CNT_W-1:0] TAIL_LD = CNT_W'(TAIL_CYC - 1);
   localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

   // a write must wait for the memory to release the bus, a read need not
   assign req_ready = (ph_q == PH_IDLE) && !(req_write && !turn_zero);
   assign accept    = req_valid && req_ready;
   assign turn_val  = TURN_LD;

   always_comb begin
      ph_d      = ph_q;
      op_load   = 1'b0;
      op_val    = '0;
      turn_load = 1'b0;
      rd_done   = 1'b0;
      unique case (ph_q)
         PH_IDLE: begin
            if (accept) begin
               op_load = 1'b1;
               if (req_write) begin
                  ph_d   = PH_WLOW;
                  op_val = WLOW_LD;
               end else begin
                  ph_d   = PH_READ;
                  op_val = RD_LD;
               end
            end
         end
         PH_READ: begin
            if (op_zero) begin
               ph_d      = PH_IDLE;
               rd_done   = 1'b1;
               turn_load = 1'b1;
            end
         end
         PH_WLOW: begin
            if (op_zero) begin
               ph_d    = PH_WTAIL;
               op_load = 1'b1;
               op_val  = TAIL_LD;
            end
         end
         PH_WTAIL: begin
            if (op_zero)
               ph_d = PH_IDLE;
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ph_q <= PH_IDLE;
      else
         ph_q <= ph_d;
   end

endmodule

// File: rtl/asram_pins.sv
// Registered pin stage: strobes, address, write data, read capture.
module asram_pins
   import asram_pkg::*;
#(
   parameter int AW       = 15,
   parameter int DW       = 8,
   parameter bit RD_RETIME = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  asram_phase_e  ph_q,
   input  asram_phase_e  ph_d,
   input  logic          accept,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          rd_done,
   input  logic [DW-1:0] mem_dq_in,
   output logic [AW-1:0] mem_addr,
   output logic          mem_cs_n,
   output logic          mem_oe_n,
   output logic          mem_we_n,
   output logic [DW-1:0] mem_dq_out,
   output logic          mem_dq_oe,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data
);

   logic          cap_valid;
   logic [DW-1:0] cap_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
         mem_cs_n   <= 1'b1;
         mem_oe_n   <= 1'b1;
         mem_we_n   <= 1'b1;
         mem_dq_oe  <= 1'b0;
      end else begin
         if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
         end
         mem_cs_n  <= !((ph_d == PH_READ) || (ph_d == PH_WLOW));
         mem_oe_n  <= !(ph_d == PH_READ);
         mem_we_n  <= !(ph_d == PH_WLOW);
         // drive with the strobe and one cycle past its rising edge
         mem_dq_oe <= (ph_d == PH_WLOW) || (ph_q == PH_WLOW);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_valid <= 1'b0;
         cap_data  <= '0;
      end else begin
         cap_valid <= rd_done;
         if (rd_done)
            cap_data <= mem_dq_in;
      end
   end

   generate
      if (RD_RETIME) begin : g_rd_retime
         logic          rt_valid;
         logic [DW-1:0] rt_data;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rt_valid <= 1'b0;
               rt_data  <= '0;
            end else begin
               rt_valid <= cap_valid;
               rt_data  <= cap_data;
            end
         end
         assign rd_valid = rt_valid;
         assign rd_data  = rt_data;
      end else begin : g_rd_direct
         assign rd_valid = cap_valid;
         assign rd_data  = cap_data;
      end
   endgenerate

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int AW        = 15,
   parameter int DW        = 8,
   parameter int CLK_NS    = 10,
   parameter int T_RC_NS   = 70,
   parameter int T_AA_NS   = 70,
   parameter int T_ACS_NS  = 70,
   parameter int T_AOE_NS  = 35,
   parameter int T_OHZ_NS  = 30,
   parameter int T_CHZ_NS  = 30,
   parameter int T_WC_NS   = 70,
   parameter int T_WP_NS   = 40,
   parameter int T_AW_NS   = 55,
   parameter int T_CW_NS   = 55,
   parameter int T_DW_NS   = 35,
   parameter bit RD_RETIME = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] mem_addr,
   output logic          mem_cs_n,
   output logic          mem_oe_n,
   output logic          mem_we_n,
   output logic [DW-1:0] mem_dq_out,
   output logic          mem_dq_oe,
   input  logic [DW-1:0] mem_dq_in
);

   localparam int RD_CYC   = imax(imax(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS)),
                                  imax(imax(ns2cyc(T_ACS_NS, CLK_NS), ns2cyc(T_AOE_NS, CLK_NS)), 1));
   localparam int WLOW_CYC = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                  imax(imax(ns2cyc(T_CW_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS)), 1));
   localparam int WC_CYC   = ns2cyc(T_WC_NS, CLK_NS);
   localparam int TAIL_CYC = imax(WC_CYC - WLOW_CYC, 2);
   localparam int TURN_CYC = imax(ns2cyc(imax(T_OHZ_NS, T_CHZ_NS), CLK_NS), 1);
   localparam int CNT_MAX  = imax(imax(RD_CYC, WLOW_CYC), imax(TAIL_CYC, TURN_CYC));
   localparam int CNT_W    = $clog2(CNT_MAX + 1);

   generate
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("asram_ctrl: address and data widths must be positive");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("asram_ctrl: clock period must be at least 1 ns");
      end
      if (T_RC_NS < 0 || T_WC_NS < 0 || T_WP_NS < 0 || T_OHZ_NS < 0) begin : g_bad_time
         $error("asram_ctrl: timing limits must be non-negative");
      end
   endgenerate

   asram_phase_e     ph_q, ph_d;
   logic             accept, op_load, turn_load, rd_done;
   logic             op_zero, turn_zero;
   logic [CNT_W-1:0] op_val, turn_val;

   asram_seq #(
      .CNT_W   (CNT_W),
      .RD_CYC  (RD_CYC),
      .WLOW_CYC(WLOW_CYC),
      .TAIL_CYC(TAIL_CYC),
      .TURN_CYC(TURN_CYC)
   ) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_write(req_write),
      .op_zero  (op_zero),
      .turn_zero(turn_zero),
      .ph_q     (ph_q),
      .ph_d     (ph_d),
      .req_ready(req_ready),
      .accept   (accept),
      .op_load  (op_load),
      .op_val   (op_val),
      .turn_load(turn_load),
      .turn_val (turn_val),
      .rd_done  (rd_done)
   );

   asram_cnt #(.W(CNT_W)) i_op_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .load (op_load),
      .val  (op_val),
      .zero (op_zero)
   );

   asram_cnt #(.W(CNT_W)) i_turn_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .load (turn_load),
      .val  (turn_val),
      .zero (turn_zero)
   );

   asram_pins #(
      .AW       (AW),
      .DW       (DW),
      .RD_RETIME(RD_RETIME)
   ) i_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .ph_q      (ph_q),
      .ph_d      (ph_d),
      .accept    (accept),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rd_done   (rd_done),
      .mem_dq_in (mem_dq_in),
      .mem_addr  (mem_addr),
      .mem_cs_n  (mem_cs_n),
      .mem_oe_n  (mem_oe_n),
      .mem_we_n  (mem_we_n),
      .mem_dq_out(mem_dq_out),
      .mem_dq_oe (mem_dq_oe),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
   parameter int AW       = 15,
   parameter int WLOW_CYC = 6,
   parameter int TURN_CYC = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic          rd_valid,
   input logic [AW-1:0] mem_addr,
   input logic          mem_cs_n,
   input logic          mem_oe_n,
   input logic          mem_we_n,
   input logic          mem_dq_oe
);

   logic [15:0] we_low_cnt;
   logic [15:0] oe_gap_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_low_cnt <= '0;
         oe_gap_cnt <= 16'hFFFF;
      end else begin
         we_low_cnt <= !mem_we_n ? we_low_cnt + 16'd1 : 16'd0;
         if (!mem_oe_n)
            oe_gap_cnt <= '0;
         else if (oe_gap_cnt != 16'hFFFF)
            oe_gap_cnt <= oe_gap_cnt + 16'd1;
      end
   end

   assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> !req_ready);

   assert_rd_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   assert_write_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs_n && mem_oe_n));

   assert_write_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_low_cnt >= 16'(WLOW_CYC)));

   assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   assert_drive_with_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> mem_dq_oe);

   assert_drive_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |=> !mem_dq_oe);

   assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

   assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> (oe_gap_cnt >= 16'(TURN_CYC)));

endmodule

bind asram_ctrl asram_ctrl_chk #(
   .AW      (AW),
   .WLOW_CYC(WLOW_CYC),
   .TURN_CYC(TURN_CYC)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_ready(req_ready),
   .rd_valid (rd_valid),
   .mem_addr (mem_addr),
   .mem_cs_n (mem_cs_n),
   .mem_oe_n (mem_oe_n),
   .mem_we_n (mem_we_n),
   .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_asram_ctrl.sv
`timescale 1ns/100ps
module test_asram_ctrl;

   // expected cycle counts at a 5 ns clock, from the requirements
   localparam int RD_EXP   = 14;  // R3: 70 ns / 5
   localparam int WLOW_EXP = 11;  // R4: 55 ns / 5
   localparam int CYC_EXP  = 14;  // R5: 70 ns / 5
   localparam int TA_EXP   = 6;   // R8: 30 ns / 5

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rd_valid;
   logic [7:0]  rd_data;
   logic [14:0] mem_addr;
   logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in = '0;

   always #2.5 clk = ~clk;

   asram_ctrl #(.CLK_NS(5)) i_asram_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- memory model (truth table, delayed output) ----------
   logic [7:0]  cells [int];
   logic [7:0]  shadow [int];
   logic [7:0]  exp_q [$];
   int          acc_cnt = 0, rel_left = 0;
   logic [14:0] acc_addr = '0;
   bit          mem_drv = 1'b0;
   int          n_wr_req = 0, n_rd_req = 0, n_wr_pulse = 0, n_rd_seen = 0;

   // ---------------- port monitors -------------
   int  rd_lo = 0, we_lo = 0, since_cs = 1000, oe_gap = 1000;
   bit  prev_cs_n = 1'b1, prev_dq_oe = 1'b0, prev_we_n = 1'b1;
   logic [14:0] prev_addr = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         // memory model: write while selected and strobed, last value wins
         if (!mem_cs_n && !mem_we_n) begin
            check(mem_dq_oe == 1'b1, "R6 drive during strobe", mem_dq_oe, 1);
            cells[int'(mem_addr)] = mem_dq_out;
         end
         if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
            acc_cnt  = (acc_cnt > 0 && acc_addr == mem_addr) ? acc_cnt + 1 : 1;
            acc_addr = mem_addr;
            rel_left = TA_EXP;
            mem_drv  = 1'b1;
         end else begin
            acc_cnt = 0;
            if (rel_left > 0) rel_left--;
            mem_drv = (rel_left > 0);
         end
         begin
            logic [7:0] v;
            v = cells.exists(int'(acc_addr)) ? cells[int'(acc_addr)] : 8'h00;
            mem_dq_in = !mem_drv ? 8'h00 : (acc_cnt >= RD_EXP ? v : (v ^ 8'hA5));
         end

         // R6 / R8: never two drivers on the bus
         check(!(mem_drv && mem_dq_oe), "R8 bus contention", int'(mem_drv && mem_dq_oe), 0);
         check(!(mem_dq_oe && !mem_oe_n), "R6 drive with output enable", int'(mem_dq_oe), 0);

         // R3 read window length
         if (!mem_cs_n && !mem_oe_n) rd_lo++;
         else if (rd_lo > 0) begin
            check(rd_lo == RD_EXP, "R3 read window", rd_lo, RD_EXP);
            rd_lo = 0;
         end
         // R4 write strobe width, with output enable high
         if (!mem_we_n) begin
            we_lo++;
            check(mem_oe_n && !mem_cs_n, "R4 strobes in write", int'(mem_oe_n), 1);
         end else if (we_lo > 0) begin
            check(we_lo >= WLOW_EXP, "R4 write strobe width", we_lo, WLOW_EXP);
            we_lo = 0;
         end
         // R6 drive released one cycle after strobe rise
         if (prev_we_n && !mem_we_n) n_wr_pulse++;
         if (!prev_we_n && mem_we_n)
            check(mem_dq_oe == 1'b1, "R6 drive held one cycle", mem_dq_oe, 1);
         // R5 spacing of select falls
         since_cs++;
         if (prev_cs_n && !mem_cs_n) begin
            check(since_cs >= CYC_EXP, "R5 cycle spacing", since_cs, CYC_EXP);
            since_cs = 0;
         end
         // R7 address held while selected
         if (!prev_cs_n && !mem_cs_n)
            check(mem_addr == prev_addr, "R7 address hold", mem_addr, prev_addr);
         // R8 turnaround
         if (!mem_oe_n) oe_gap = 0; else if (oe_gap < 1000) oe_gap++;
         if (!prev_dq_oe && mem_dq_oe)
            check(oe_gap >= TA_EXP, "R8 turnaround", oe_gap, TA_EXP);
         // R2 ready low while busy
         if (!mem_cs_n) check(!req_ready, "R2 ready while busy", req_ready, 0);
         // R3 / R9 read data
         if (rd_valid) begin
            n_rd_seen++;
            if (exp_q.size() == 0)
               check(1'b0, "R2 spurious read valid", 1, 0);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               check(rd_data == e, "R9 readback", rd_data, e);
            end
         end
         prev_cs_n  = mem_cs_n;
         prev_we_n  = mem_we_n;
         prev_dq_oe = mem_dq_oe;
         prev_addr  = mem_addr;
      end
   end

   // ---------------- stimulus -----------------
   logic [31:0] lfsr = 32'h1D2C3B4A;
   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] x;
      x = s ^ (s << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   task automatic issue(input bit wr, input int a, input logic [7:0] d);
      bit taken;
      taken = 1'b0;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = 15'(a);
      req_wdata = d;
      while (!taken) begin
         #1;
         if (req_ready) begin
            @(posedge clk);
            taken = 1'b1;
            #1;
            req_valid = 1'b0;
         end else
            @(negedge clk);
      end
      if (wr) begin
         shadow[a] = d;
         n_wr_req++;
      end else begin
         exp_q.push_back(shadow.exists(a) ? shadow[a] : 8'h00);
         n_rd_req++;
      end
   endtask

   int addrs [$];

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes in reset", {mem_cs_n, mem_oe_n, mem_we_n}, 7);
      check(!mem_dq_oe, "R1 drive in reset", mem_dq_oe, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready, "R1 ready after reset", req_ready, 1);
      check(!rd_valid, "R1 no read valid after reset", rd_valid, 0);

      // R9 corner addresses, write-after-write and read-after-read
      issue(1'b1, 0, 8'h3C);
      issue(1'b1, 32767, 8'hC3);
      issue(1'b0, 0, 8'h00);
      issue(1'b0, 32767, 8'h00);
      // R8 write right behind a read, then read back
      issue(1'b1, 0, 8'h81);
      issue(1'b0, 0, 8'h00);

      // random fill
      for (int i = 0; i < 150; i++) begin
         int a;
         lfsr = nxt(lfsr);
         a = int'(lfsr[14:0]);
         addrs.push_back(a);
         issue(1'b1, a, lfsr[23:16]);
      end
      // readback, with read->write->read interleave for turnaround
      foreach (addrs[i]) begin
         issue(1'b0, addrs[i], 8'h00);
         if (i % 3 == 0) begin
            lfsr = nxt(lfsr);
            issue(1'b1, addrs[i], lfsr[7:0]);
            issue(1'b0, addrs[i], 8'h00);
         end
      end
      issue(1'b0, 32767, 8'h00);

      repeat (40) @(negedge clk);
      // R2 one strobe cycle per accepted request
      check(n_wr_pulse == n_wr_req, "R2 write pulses per request", n_wr_pulse, n_wr_req);
      check(n_rd_seen == n_rd_req, "R2 read results per request", n_rd_seen, n_rd_req);
      check(exp_q.size() == 0, "R3 pending reads", exp_q.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule